// File: doc/BRIEF.md
# Host Memory Access Port

This block is a slave port through which an external host reads and writes a processor's on-chip program memory and data memory while the core keeps running. The host uses one 16-bit bus that carries both address and data, at different times. It controls the port with four strobes: select, address latch, read and write. It watches an acknowledge output to pace itself. Inside the chip, the port asks for each memory cycle through a request/grant handshake. There is one handshake for the 24-bit program array and another for the 16-bit data array.

A host first sends one control word. That word either sets the transfer pointer (address and destination) or loads a small overlay register. After that, the host runs plain read and write strobes. The pointer steps forward by itself after each completed access, so a whole block moves after one starting address. A program word is 24 bits wide, so it crosses the bus as two transfers: the upper part first, then the low byte. The strobes are asynchronous to the core clock. They pass through a synchroniser before any decision is taken.

Top module: `host_mem_port`

## Requirements
- R1: A control word with bit 15 = 0, captured when address latch falls while select is held, sets the pointer to bits 13:0 and the destination to bit 14 (1 = data memory, 0 = program memory). Later transfers use that location.
- R2: A control word with bit 15 = 1 loads the overlay register instead. The program field takes bits 3:0 and the data field takes bits 7:4. Bits 15:8 of `ovl_word` read as zero. The transfer pointer is left unchanged.
- R3: Each completed data-memory transfer advances the pointer by one. The pointer wraps from 0x3FFF to 0x0000.
- R4: A program-memory write takes two transfers. The first holds the upper 16 bits and causes no memory request. The second supplies bits 7:0 in the low byte of the bus. Only then is the word {first, second[7:0]} written and the pointer advanced.
- R5: A program-memory read takes two transfers backed by a single memory read. The first returns word bits 23:8. The second returns {8'h00, bits 7:0}.
- R6: `host_ack` is high while the port is idle. It drops on the clock edge that accepts a strobe and stays low for 1 + g cycles, where g is the number of cycles the grant is withheld. For transfers that need no memory access, g is 0.
- R7: `host_bus_oe` is high exactly while select and read are both asserted at the pins.
- R8: After reset, `host_ack` is high, `ovl_word` is zero, and neither memory request is asserted.
- R9: A strobe held asserted produces one transfer only. A new transfer needs the strobe to be released first.
- R10: The two memory requests are never asserted together. A request is held, with a stable address, until it is granted.
- R11: Toggling address latch while select is deasserted changes neither the pointer nor the overlay register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| host_sel_n | input | 1 | Port select, active low, asynchronous |
| host_lat | input | 1 | Address latch, active high, control word taken on its fall |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_bus_in | input | 16 | Bus value driven by the host |
| host_bus_out | output | 16 | Read data toward the host |
| host_bus_oe | output | 1 | Output enable for the bus pads |
| host_ack | output | 1 | Ready/acknowledge to the host |
| pm_req | output | 1 | Program memory request |
| pm_we | output | 1 | Program memory write enable |
| pm_addr | output | 14 | Program memory address |
| pm_wdata | output | 24 | Program memory write word |
| pm_rdata | input | 24 | Program memory read word, valid with grant |
| pm_gnt | input | 1 | Program memory grant |
| dm_req | output | 1 | Data memory request |
| dm_we | output | 1 | Data memory write enable |
| dm_addr | output | 14 | Data memory address |
| dm_wdata | output | 16 | Data memory write word |
| dm_rdata | input | 16 | Data memory read word, valid with grant |
| dm_gnt | input | 1 | Data memory grant |
| ovl_word | output | 16 | Overlay register (data field 7:4, program field 3:0) |

## Verification
On every cycle, the assertions check the following: the two memory requests never overlap, a waiting request keeps its address, a program write reaches memory only on the second half of a word, and a granted data-memory access advances the pointer by exactly one. Other behaviours are visible only in the bench's scenarios. These are the split of 24-bit words across two bus transfers, the returned read values, the acknowledge length under different grant delays, a held strobe giving a single transfer, the overlay write leaving the pointer alone, and the pointer wrap.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
    localparam int HB_W      = 16;               // host bus width
    localparam int HA_W      = 14;               // memory address width
    localparam int PM_W      = 24;               // program word width
    localparam int OVL_FLD_W = 4;                // width of each overlay field
    localparam int LO_W      = PM_W - HB_W;      // low part of a program word
    localparam int DST_BIT   = HA_W;             // destination select bit
    localparam int OVL_BIT   = HB_W - 1;         // overlay redirect bit

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_HOLD = 2'd2
    } eng_st_e;

    typedef struct packed {
        eng_st_e          st;
        logic             lat_q;
        logic             is_wr;
        logic [HB_W-1:0]  wdat;
        logic [HB_W-1:0]  rdat;
        logic             half;
        logic [HB_W-1:0]  hi_buf;
        logic [LO_W-1:0]  lo_buf;
    } eng_s;

    typedef struct packed {
        logic [HA_W-1:0]  addr;
        logic             dst;
    } ptr_s;
endpackage

// File: rtl/hmp_sync.sv
module hmp_sync #(
    parameter int W      = 4,
    parameter int STAGES = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= '0;
                else        chain_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= '0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hmp_ovl_reg.sv
module hmp_ovl_reg
    import hmp_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [2*OVL_FLD_W-1:0]   din,
    output logic [HB_W-1:0]          ovl_word
);
    logic [HB_W-1:0] ovl_d, ovl_q;

    always_comb begin
        ovl_d = ovl_q;
        if (we) begin
            ovl_d = '0;
            ovl_d[OVL_FLD_W-1:0]           = din[OVL_FLD_W-1:0];
            ovl_d[2*OVL_FLD_W-1:OVL_FLD_W] = din[2*OVL_FLD_W-1:OVL_FLD_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovl_q <= '0;
        else        ovl_q <= ovl_d;
    end

    assign ovl_word = ovl_q;
endmodule

// File: rtl/hmp_engine.sv
module hmp_engine
    import hmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_sel,
    input  logic             s_lat,
    input  logic             s_rd,
    input  logic             s_wr,
    input  logic [HB_W-1:0]  bus_in,
    output logic             ovl_we,
    output logic             ack,
    output logic [HB_W-1:0]  rd_data,
    output logic             pm_req,
    output logic             pm_we,
    output logic [HA_W-1:0]  pm_addr,
    output logic [PM_W-1:0]  pm_wdata,
    input  logic [PM_W-1:0]  pm_rdata,
    input  logic             pm_gnt,
    output logic             dm_req,
    output logic             dm_we,
    output logic [HA_W-1:0]  dm_addr,
    output logic [HB_W-1:0]  dm_wdata,
    input  logic [HB_W-1:0]  dm_rdata,
    input  logic             dm_gnt
);
    eng_s e_d, e_q;
    ptr_s p_d, p_q;

    logic lat_fall, xfer, need_mem, mem_ok;

    always_comb begin
        e_d      = e_q;
        p_d      = p_q;
        ovl_we   = 1'b0;
        lat_fall = e_q.lat_q & ~s_lat & s_sel;
        xfer     = s_sel & (s_rd | s_wr);
        // program words touch memory on the first read half and the second write half
        need_mem = p_q.dst | (e_q.is_wr ? e_q.half : ~e_q.half);
        mem_ok   = p_q.dst ? dm_gnt : pm_gnt;
        e_d.lat_q = s_lat;

        unique case (e_q.st)
            ST_IDLE: begin
                if (lat_fall) begin
                    if (bus_in[OVL_BIT]) begin
                        ovl_we = 1'b1;
                    end else begin
                        p_d.addr  = bus_in[HA_W-1:0];
                        p_d.dst   = bus_in[DST_BIT];
                        e_d.half  = 1'b0;
                    end
                end else if (xfer) begin
                    e_d.st    = ST_ACC;
                    e_d.is_wr = s_wr;
                    e_d.wdat  = bus_in;
                end
            end
            ST_ACC: begin
                if (!need_mem || mem_ok) begin
                    e_d.st = ST_HOLD;
                    if (p_q.dst) begin
                        if (!e_q.is_wr) e_d.rdat = dm_rdata;
                        p_d.addr = p_q.addr + 1'b1;
                    end else if (!e_q.half) begin
                        if (e_q.is_wr) begin
                            e_d.hi_buf = e_q.wdat;
                        end else begin
                            e_d.rdat   = pm_rdata[PM_W-1:LO_W];
                            e_d.lo_buf = pm_rdata[LO_W-1:0];
                        end
                        e_d.half = 1'b1;
                    end else begin
                        if (!e_q.is_wr) e_d.rdat = {{(HB_W-LO_W){1'b0}}, e_q.lo_buf};
                        e_d.half = 1'b0;
                        p_d.addr = p_q.addr + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (!xfer) e_d.st = ST_IDLE;
            end
            default: e_d.st = ST_IDLE;
        endcase

        pm_req   = (e_q.st == ST_ACC) & ~p_q.dst & need_mem;
        dm_req   = (e_q.st == ST_ACC) &  p_q.dst;
        pm_we    = e_q.is_wr;
        dm_we    = e_q.is_wr;
        pm_addr  = p_q.addr;
        dm_addr  = p_q.addr;
        pm_wdata = {e_q.hi_buf, e_q.wdat[LO_W-1:0]};
        dm_wdata = e_q.wdat;
        ack      = (e_q.st != ST_ACC);
        rd_data  = e_q.rdat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{st: ST_IDLE, default: '0};
        end else begin
            e_q <= e_d;
        end
    end

    // pointer is left undefined at reset
    always_ff @(posedge clk) begin
        p_q <= p_d;
    end

    assert_req_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pm_req && dm_req));

    assert_pm_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_req && !pm_gnt) |=> (pm_req && $stable(pm_addr)));

    assert_dm_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_req && !dm_gnt) |=> (dm_req && $stable(dm_addr)));

    assert_pm_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_req && pm_we) |-> e_q.half);

    assert_dm_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_req && dm_gnt) |=> (dm_addr == $past(dm_addr) + 1'b1));
endmodule

// File: rtl/host_mem_port.sv
module host_mem_port
    import hmp_pkg::*;
#(
    parameter int SYNC_STAGES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_sel_n,
    input  logic             host_lat,
    input  logic             host_rd_n,
    input  logic             host_wr_n,
    input  logic [15:0]      host_bus_in,
    output logic [15:0]      host_bus_out,
    output logic             host_bus_oe,
    output logic             host_ack,
    output logic             pm_req,
    output logic             pm_we,
    output logic [13:0]      pm_addr,
    output logic [23:0]      pm_wdata,
    input  logic [23:0]      pm_rdata,
    input  logic             pm_gnt,
    output logic             dm_req,
    output logic             dm_we,
    output logic [13:0]      dm_addr,
    output logic [15:0]      dm_wdata,
    input  logic [15:0]      dm_rdata,
    input  logic             dm_gnt,
    output logic [15:0]      ovl_word
);
    localparam int NSTROBE = 4;

    logic [NSTROBE-1:0] raw_strb, syn_strb;
    logic               ovl_we;

    assign raw_strb = {~host_sel_n, host_lat, ~host_rd_n, ~host_wr_n};

    hmp_sync #(.W(NSTROBE), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_strb),
        .q     (syn_strb)
    );

    hmp_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_sel    (syn_strb[3]),
        .s_lat    (syn_strb[2]),
        .s_rd     (syn_strb[1]),
        .s_wr     (syn_strb[0]),
        .bus_in   (host_bus_in),
        .ovl_we   (ovl_we),
        .ack      (host_ack),
        .rd_data  (host_bus_out),
        .pm_req   (pm_req),
        .pm_we    (pm_we),
        .pm_addr  (pm_addr),
        .pm_wdata (pm_wdata),
        .pm_rdata (pm_rdata),
        .pm_gnt   (pm_gnt),
        .dm_req   (dm_req),
        .dm_we    (dm_we),
        .dm_addr  (dm_addr),
        .dm_wdata (dm_wdata),
        .dm_rdata (dm_rdata),
        .dm_gnt   (dm_gnt)
    );

    hmp_ovl_reg u_ovl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ovl_we),
        .din      (host_bus_in[2*OVL_FLD_W-1:0]),
        .ovl_word (ovl_word)
    );

    // pads drive only during a selected read, straight from the pins
    assign host_bus_oe = ~host_sel_n & ~host_rd_n;
endmodule

// File: tb/sim_host_mem_port.sv
module sim_host_mem_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, lat = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [15:0] bus_in = '0;
    logic [15:0] bus_out, dm_wdata, dm_rdata, ovl_word;
    logic bus_oe, ack, pm_req, pm_we, pm_gnt, dm_req, dm_we, dm_gnt;
    logic [13:0] pm_addr, dm_addr;
    logic [23:0] pm_wdata, pm_rdata;

    int checks = 0, errors = 0;
    int gdel = 0, wcnt = 0;
    int pm_wr_cnt = 0, pm_rd_cnt = 0, dm_wr_cnt = 0;
    logic [13:0] last_dm_waddr;
    logic [23:0] pmem [256];
    logic [15:0] dmem [256];

    // reference model of the pointer
    bit model_on = 0;
    int exp_addr = 0;
    bit exp_dst = 0;
    bit exp_half = 0;

    always #10 clk = ~clk;

    host_mem_port u0 (
        .clk(clk), .rst_n(rst_n), .host_sel_n(sel_n), .host_lat(lat),
        .host_rd_n(rd_n), .host_wr_n(wr_n), .host_bus_in(bus_in),
        .host_bus_out(bus_out), .host_bus_oe(bus_oe), .host_ack(ack),
        .pm_req(pm_req), .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
        .pm_rdata(pm_rdata), .pm_gnt(pm_gnt), .dm_req(dm_req), .dm_we(dm_we),
        .dm_addr(dm_addr), .dm_wdata(dm_wdata), .dm_rdata(dm_rdata),
        .dm_gnt(dm_gnt), .ovl_word(ovl_word)
    );

    assign pm_gnt   = pm_req && (wcnt >= gdel);
    assign dm_gnt   = dm_req && (wcnt >= gdel);
    assign pm_rdata = pmem[pm_addr[7:0]];
    assign dm_rdata = dmem[dm_addr[7:0]];

    always @(posedge clk) begin
        if ((pm_req && !pm_gnt) || (dm_req && !dm_gnt)) wcnt <= wcnt + 1;
        else wcnt <= 0;
        if (pm_req && pm_gnt && pm_we) begin
            pmem[pm_addr[7:0]] <= pm_wdata;
            pm_wr_cnt <= pm_wr_cnt + 1;
        end
        if (pm_req && pm_gnt && !pm_we) pm_rd_cnt <= pm_rd_cnt + 1;
        if (dm_req && dm_gnt && dm_we) begin
            dmem[dm_addr[7:0]] <= dm_wdata;
            dm_wr_cnt <= dm_wr_cnt + 1;
            last_dm_waddr <= dm_addr;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the reference pointer
    always @(negedge clk) begin
        if (rst_n && model_on && (pm_req || dm_req)) begin
            chk(!(pm_req && dm_req), "R10", {30'd0, pm_req, dm_req}, 32'd0);
            chk(dm_req == exp_dst, "R1", {31'd0, dm_req}, {31'd0, exp_dst});
            chk((dm_req ? dm_addr : pm_addr) == exp_addr[13:0], "R1",
                {18'd0, (dm_req ? dm_addr : pm_addr)}, exp_addr);
        end
    end

    task automatic send_ctrl(input logic [15:0] w);
        @(negedge clk);
        bus_in = w; sel_n = 1'b0; lat = 1'b1;
        repeat (3) @(negedge clk);
        lat = 1'b0;
        repeat (3) @(negedge clk);
        sel_n = 1'b1;
        repeat (2) @(negedge clk);
        if (!w[15]) begin
            exp_addr = w[13:0]; exp_dst = w[14]; exp_half = 0;
        end
    endtask

    task automatic step_model();
        if (exp_dst || exp_half) exp_addr = (exp_addr + 1) & 16'h3FFF;
        if (!exp_dst) exp_half = !exp_half;
    endtask

    task automatic xfer(input bit is_wr, input logic [15:0] d, input int hold,
                        output logic [15:0] rdat, output int lowcyc);
        int guard;
        @(negedge clk);
        bus_in = d; sel_n = 1'b0;
        if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
        guard = 0;
        while (ack && guard < 50) begin @(negedge clk); guard++; end
        lowcyc = 0;
        while (!ack && lowcyc < 50) begin lowcyc++; @(negedge clk); end
        rdat = bus_out;
        if (!is_wr) chk(bus_oe == 1'b1, "R7", {31'd0, bus_oe}, 32'd1);
        repeat (hold) @(negedge clk);
        sel_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
        repeat (3) @(negedge clk);
        step_model();
    endtask

    initial begin
        int lc, n0;
        logic [15:0] rv;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(ack == 1'b1, "R8", {31'd0, ack}, 32'd1);
        chk(ovl_word == 16'h0, "R8", {16'd0, ovl_word}, 32'd0);
        chk(!pm_req && !dm_req, "R8", {30'd0, pm_req, dm_req}, 32'd0);
        chk(bus_oe == 1'b0, "R7", {31'd0, bus_oe}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        model_on = 1;

        // R1, R3, R6: data memory writes at 0x0010
        send_ctrl(16'h4010);
        xfer(1, 16'h1234, 0, rv, lc);
        chk(lc == 1, "R6", lc, 1);
        xfer(1, 16'hABCD, 0, rv, lc);
        chk(dmem[8'h10] == 16'h1234, "R1", {16'd0, dmem[8'h10]}, 32'h1234);
        chk(dmem[8'h11] == 16'hABCD, "R3", {16'd0, dmem[8'h11]}, 32'hABCD);

        // R1, R3: read back through a new pointer
        send_ctrl(16'h4010);
        xfer(0, 16'h0, 0, rv, lc);
        chk(rv == 16'h1234, "R1", {16'd0, rv}, 32'h1234);
        xfer(0, 16'h0, 0, rv, lc);
        chk(rv == 16'hABCD, "R3", {16'd0, rv}, 32'hABCD);

        // R6: grant withheld two cycles
        gdel = 2;
        xfer(1, 16'h5555, 0, rv, lc);
        chk(lc == 3, "R6", lc, 3);
        chk(dmem[8'h12] == 16'h5555, "R10", {16'd0, dmem[8'h12]}, 32'h5555);
        gdel = 0;

        // R4: program word written in two halves
        send_ctrl(16'h0005);
        n0 = pm_wr_cnt;
        xfer(1, 16'hBEEF, 0, rv, lc);
        chk(pm_wr_cnt == n0, "R4", pm_wr_cnt, n0);
        chk(lc == 1, "R6", lc, 1);
        xfer(1, 16'h3377, 0, rv, lc);
        chk(pm_wr_cnt == n0 + 1, "R4", pm_wr_cnt, n0 + 1);
        chk(pmem[8'h05] == 24'hBEEF77, "R4", {8'd0, pmem[8'h05]}, 32'hBEEF77);

        // R5: program word read in two halves, one memory read
        send_ctrl(16'h0005);
        n0 = pm_rd_cnt;
        xfer(0, 16'h0, 0, rv, lc);
        chk(rv == 16'hBEEF, "R5", {16'd0, rv}, 32'hBEEF);
        xfer(0, 16'h0, 0, rv, lc);
        chk(rv == 16'h0077, "R5", {16'd0, rv}, 32'h0077);
        chk(pm_rd_cnt == n0 + 1, "R5", pm_rd_cnt, n0 + 1);

        // R2: overlay write leaves the pointer alone
        send_ctrl(16'h4020);
        xfer(1, 16'h0A0A, 0, rv, lc);
        send_ctrl(16'hDFA3);
        chk(ovl_word == 16'h00A3, "R2", {16'd0, ovl_word}, 32'h00A3);
        xfer(1, 16'h0B0B, 0, rv, lc);
        chk(last_dm_waddr == 14'h0021, "R2", {18'd0, last_dm_waddr}, 32'h21);

        // R11: latch toggled without select
        @(negedge clk);
        bus_in = 16'h4030; lat = 1'b1;
        repeat (3) @(negedge clk);
        lat = 1'b0;
        repeat (3) @(negedge clk);
        bus_in = 16'h80FF; lat = 1'b1;
        repeat (3) @(negedge clk);
        lat = 1'b0;
        repeat (3) @(negedge clk);
        chk(ovl_word == 16'h00A3, "R11", {16'd0, ovl_word}, 32'h00A3);
        xfer(1, 16'h0C0C, 0, rv, lc);
        chk(last_dm_waddr == 14'h0022, "R11", {18'd0, last_dm_waddr}, 32'h22);

        // R9: strobe held long gives one transfer
        n0 = dm_wr_cnt;
        xfer(1, 16'h0D0D, 12, rv, lc);
        chk(dm_wr_cnt == n0 + 1, "R9", dm_wr_cnt, n0 + 1);

        // R7: read strobe without select does not drive or start a transfer
        @(negedge clk);
        rd_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(bus_oe == 1'b0, "R7", {31'd0, bus_oe}, 32'd0);
        chk(ack == 1'b1, "R9", {31'd0, ack}, 32'd1);
        rd_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3: wrap at the top of the address space
        send_ctrl(16'h7FFF);
        xfer(1, 16'h1111, 0, rv, lc);
        chk(last_dm_waddr == 14'h3FFF, "R3", {18'd0, last_dm_waddr}, 32'h3FFF);
        xfer(1, 16'h2222, 0, rv, lc);
        chk(last_dm_waddr == 14'h0000, "R3", {18'd0, last_dm_waddr}, 32'h0);
        chk(dmem[8'h00] == 16'h2222, "R3", {16'd0, dmem[8'h00]}, 32'h2222);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule